// File: doc/BRIEF.md
# Mode-Gated Event Performance Counters

This block counts hardware events with three independent counters that share one packed 64-bit control and status word. Each counter picks one strobe from a 16-wide event vector. It advances by one in every clock cycle where that strobe is high, its two-bit control field is non-zero, and the current processor mode is not masked by the kill bits. Each counter can request an interrupt when it crosses a boundary. The boundary is either every 256 counts or the wrap of the counter's full range.

Software reads the whole word combinationally on `rd_data`. A write replaces the whole word in one cycle. A write takes priority over any increment that the same cycle would have made. The three interrupt request lines pulse for one cycle each. Collecting and delivering those requests is left to the surrounding logic.

Top module: `pmon_unit`

## Requirements
- R1: After reset every field of the word reads zero, every control field is 00 (counting off), and all `irq` lines are low.
- R2: A write with `wr_en` high loads all fields. Counter A sits at bits 63:48 (16 bits), counter B at 47:32 (16 bits) and counter C at 29:16 (14 bits). Select A is bit 31, user kill is bit 30, and the controls of A, B and C are at 15:14, 13:12 and 11:10. Firmware kill is bit 9, supervisor-class kill is bit 8, select B is 7:4 and select C is 3:0. `rd_data` returns the stored word in the cycle after the write.
- R3: With control 00 a counter holds its value. With control 01, 10 or 11 it adds one in each cycle where its selected event is high and counting is allowed in the current mode.
- R4: Counter A counts `evt[0]` when its select bit is 0 and `evt[1]` when it is 1. Counter B counts `evt[selB]` and counter C counts `evt[selC]`.
- R5: Mode codes are 0 user, 1 kernel, 2 executive, 3 supervisor and 4 firmware. Codes 5 to 7 never count. Unless all three kill bits are set, the user kill stops counting in mode 0, the firmware kill stops it in mode 4, and the supervisor-class kill stops it in modes 1, 2 and 3.
- R6: With all three kill bits set, counting happens in modes 2 and 3 only.
- R7: With control 11, `irq[i]` is high for exactly the one cycle after an increment that leaves the low 8 bits of the counter at zero.
- R8: With control 10, `irq[i]` is high for the one cycle after an increment that wraps the counter from all ones to zero. This is after 65536 counts for A and B and after 16384 counts for C. Control 01 never raises `irq`.
- R9: A write in the same cycle as an enabled event loads the written value, with no increment and no interrupt pulse.
- R10: Counters wrap modulo their width (2^16 for A and B, 2^14 for C).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write the whole control/status word |
| wr_data | input | 64 | Word to write |
| rd_data | output | 64 | Current control/status word |
| evt | input | 16 | Event strobes, one per index |
| mode | input | 3 | Current processor mode code |
| irq | output | 3 | Per-counter one-cycle interrupt requests (bit 0 = A) |

## Verification
The bench preloads counters just below each boundary. A design that compared against the wrong bit pattern would pulse a cycle early or late, or would miss the 14-bit wrap of counter C. The bench sweeps all eight mode codes under each single kill bit and under all three together. A gate that checked the kill bits one at a time would then stop executive and supervisor counting too, and a gate that ignored the reserved codes would count in them. It also writes while events are active. An increment that won over the write would show up as a value one above the written word or as a stray pulse.

// File: rtl/pmon_pkg.sv
`timescale 1ns/1ps
package pmon_pkg;
  localparam int NCTR  = 3;
  localparam int EVT_N = 16;
  localparam int SEL_W = $clog2(EVT_N);
  localparam int WORD_W = 64;
  localparam int CTR_W   [NCTR] = '{16, 16, 14};
  localparam int CTR_LSB [NCTR] = '{48, 32, 16};

  typedef enum logic [2:0] {
    MD_USER   = 3'd0,
    MD_KERNEL = 3'd1,
    MD_EXEC   = 3'd2,
    MD_SUPER  = 3'd3,
    MD_FW     = 3'd4
  } pmon_mode_e;

  typedef enum logic [1:0] {
    CT_OFF  = 2'b00,
    CT_RUN  = 2'b01,
    CT_WRAP = 2'b10,
    CT_P256 = 2'b11
  } pmon_ctl_e;

  typedef struct packed {
    logic             sel_a;
    logic             kill_usr;
    logic             kill_fw;
    logic             kill_sup;
    logic [1:0]       ctl_a;
    logic [1:0]       ctl_b;
    logic [1:0]       ctl_c;
    logic [SEL_W-1:0] sel_b;
    logic [SEL_W-1:0] sel_c;
  } pmon_cfg_t;

  function automatic pmon_cfg_t cfg_decode(input logic [WORD_W-1:0] w);
    pmon_cfg_t c;
    c.sel_a    = w[31];
    c.kill_usr = w[30];
    c.ctl_a    = w[15:14];
    c.ctl_b    = w[13:12];
    c.ctl_c    = w[11:10];
    c.kill_fw  = w[9];
    c.kill_sup = w[8];
    c.sel_b    = w[7:4];
    c.sel_c    = w[3:0];
    return c;
  endfunction
endpackage

// File: rtl/pmon_rst_sync.sv
`timescale 1ns/1ps
module pmon_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pmon_gate.sv
`timescale 1ns/1ps
module pmon_gate
  import pmon_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       kill_usr,
  input  logic       kill_fw,
  input  logic       kill_sup,
  output logic       allow
);
  logic all_kill;
  logic mid_mode;

  assign all_kill = kill_usr & kill_fw & kill_sup;
  assign mid_mode = (mode == MD_EXEC) || (mode == MD_SUPER);

  always_comb begin
    allow = 1'b0;
    if (all_kill) begin
      allow = mid_mode;
    end else begin
      unique case (mode)
        MD_USER:                     allow = ~kill_usr;
        MD_KERNEL, MD_EXEC, MD_SUPER: allow = ~kill_sup;
        MD_FW:                       allow = ~kill_fw;
        default:                     allow = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pmon_counter.sv
`timescale 1ns/1ps
module pmon_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [1:0]   ctl,
  input  logic         allow,
  input  logic         ev,
  output logic [W-1:0] cnt,
  output logic         irq
);
  localparam logic [1:0] C_OFF  = 2'b00;
  localparam logic [1:0] C_WRAP = 2'b10;
  localparam logic [1:0] C_P256 = 2'b11;

  logic [W-1:0] cnt_d;
  logic         irq_d;
  logic         inc;
  logic         hit_wrap;
  logic         hit_p256;

  assign inc      = (ctl != C_OFF) && allow && ev;
  assign hit_wrap = &cnt;
  assign hit_p256 = &cnt[7:0];

  always_comb begin
    cnt_d = cnt;
    irq_d = 1'b0;
    if (ld) begin
      cnt_d = ld_val;
    end else if (inc) begin
      cnt_d = cnt + 1'b1;
      irq_d = ((ctl == C_WRAP) && hit_wrap) || ((ctl == C_P256) && hit_p256);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      cnt <= cnt_d;
      irq <= irq_d;
    end
  end

  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == $past(ld_val)));
  p_irq_only_on_zero_low_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt[7:0] == 8'h00));
  p_irq_needs_period_ctl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctl[1]);
  p_off_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && ctl == C_OFF) |=> $stable(cnt));
  p_step_by_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> ((cnt == $past(cnt)) || (cnt == W'($past(cnt) + 1'b1))));
endmodule

// File: rtl/pmon_unit.sv
`timescale 1ns/1ps
module pmon_unit
  import pmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [63:0]       wr_data,
  output logic [63:0]       rd_data,
  input  logic [EVT_N-1:0]  evt,
  input  logic [2:0]        mode,
  output logic [NCTR-1:0]   irq
);
  logic                        rst_i_n;
  pmon_cfg_t                   cfg_q;
  pmon_cfg_t                   cfg_d;
  logic                        allow;
  logic [NCTR-1:0][1:0]        ctl_vec;
  logic [NCTR-1:0][SEL_W-1:0]  sel_vec;
  logic [NCTR-1:0][15:0]       cnt_ext;

  pmon_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = cfg_decode(wr_data);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) cfg_q <= '0;
    else          cfg_q <= cfg_d;
  end

  pmon_gate u_gate (
    .mode     (mode),
    .kill_usr (cfg_q.kill_usr),
    .kill_fw  (cfg_q.kill_fw),
    .kill_sup (cfg_q.kill_sup),
    .allow    (allow)
  );

  assign ctl_vec[0] = cfg_q.ctl_a;
  assign ctl_vec[1] = cfg_q.ctl_b;
  assign ctl_vec[2] = cfg_q.ctl_c;
  assign sel_vec[0] = {{(SEL_W-1){1'b0}}, cfg_q.sel_a};
  assign sel_vec[1] = cfg_q.sel_b;
  assign sel_vec[2] = cfg_q.sel_c;

  for (genvar i = 0; i < NCTR; i++) begin : g_ctr
    localparam int W   = CTR_W[i];
    localparam int LSB = CTR_LSB[i];
    logic [W-1:0] cnt;
    logic         ev_sel;

    assign ev_sel = evt[sel_vec[i]];

    pmon_counter #(.W(W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_i_n),
      .ld     (wr_en),
      .ld_val (wr_data[LSB +: W]),
      .ctl    (ctl_vec[i]),
      .allow  (allow),
      .ev     (ev_sel),
      .cnt    (cnt),
      .irq    (irq[i])
    );

    assign rd_data[LSB +: W] = cnt;
    assign cnt_ext[i]        = 16'(cnt);
  end

  assign rd_data[31]    = cfg_q.sel_a;
  assign rd_data[30]    = cfg_q.kill_usr;
  assign rd_data[15:14] = cfg_q.ctl_a;
  assign rd_data[13:12] = cfg_q.ctl_b;
  assign rd_data[11:10] = cfg_q.ctl_c;
  assign rd_data[9]     = cfg_q.kill_fw;
  assign rd_data[8]     = cfg_q.kill_sup;
  assign rd_data[7:4]   = cfg_q.sel_b;
  assign rd_data[3:0]   = cfg_q.sel_c;

  p_allkill_blocks_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cfg_q.kill_usr && cfg_q.kill_fw && cfg_q.kill_sup && !wr_en &&
     !(mode == MD_EXEC || mode == MD_SUPER)) |=> $stable(cnt_ext));
  p_reserved_mode_idle_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!wr_en && mode > 3'd4) |=> ($stable(cnt_ext) && irq == '0));
  p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_en |=> (rd_data[31:0] == $past(wr_data[31:0]) || rd_data[31] != $past(wr_data[31])) == 1'b1 ? rd_data[15:0] == $past(wr_data[15:0]) : 1'b0);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_i_n |-> (irq == '0));
endmodule

// File: tb/pmon_unit_test.sv
`timescale 1ns/1ps
module pmon_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [63:0] wr_data;
  logic [63:0] rd_data;
  logic [15:0] evt;
  logic [2:0]  mode;
  logic [2:0]  irq;

  always #2.5 clk = ~clk;

  pmon_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .evt(evt), .mode(mode), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // reference state
  logic [15:0] m0, m1;
  logic [13:0] m2;
  logic        s0, ku, kp, kk;
  logic [3:0]  s1, s2;
  logic [1:0]  c0, c1, c2;

  // scoreboard queues
  int          q_tgt[$];
  logic [63:0] q_rd[$];
  logic [2:0]  q_irq[$];
  string       q_req[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] mpack();
    return {m0, m1, s0, ku, m2, c0, c1, c2, kp, kk, s1, s2};
  endfunction

  function automatic logic [63:0] mkw(input logic [15:0] a, input logic [15:0] b,
      input logic [13:0] c, input logic sa, input logic k_u, input logic k_p,
      input logic k_k, input logic [1:0] x0, input logic [1:0] x1,
      input logic [1:0] x2, input logic [3:0] y1, input logic [3:0] y2);
    return {a, b, sa, k_u, c, x0, x1, x2, k_p, k_k, y1, y2};
  endfunction

  function automatic bit allowed(input logic [2:0] md);
    if (md > 3'd4) return 1'b0;
    if (ku && kp && kk) return (md == 3'd2) || (md == 3'd3);
    case (md)
      3'd0:    return !ku;
      3'd4:    return !kp;
      default: return !kk;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected outcome
  task automatic drive(input bit wr, input logic [63:0] w, input logic [15:0] ev,
                       input logic [2:0] md, input string req);
    logic [2:0] ei;
    bit ok;
    @(posedge clk);
    #1;
    wr_en = wr; wr_data = w; evt = ev; mode = md;
    ei = 3'b000;
    ok = allowed(md);
    if (wr) begin
      {m0, m1, s0, ku, m2, c0, c1, c2, kp, kk, s1, s2} = w;
    end else begin
      if (c0 != 2'b00 && ok && ev[s0]) begin
        ei[0] = (c0 == 2'b10 && m0 == 16'hFFFF) || (c0 == 2'b11 && m0[7:0] == 8'hFF);
        m0 = m0 + 16'd1;
      end
      if (c1 != 2'b00 && ok && ev[s1]) begin
        ei[1] = (c1 == 2'b10 && m1 == 16'hFFFF) || (c1 == 2'b11 && m1[7:0] == 8'hFF);
        m1 = m1 + 16'd1;
      end
      if (c2 != 2'b00 && ok && ev[s2]) begin
        ei[2] = (c2 == 2'b10 && m2 == 14'h3FFF) || (c2 == 2'b11 && m2[7:0] == 8'hFF);
        m2 = m2 + 14'd1;
      end
    end
    q_tgt.push_back(cyc + 1);
    q_rd.push_back(mpack());
    q_irq.push_back(ei);
    q_req.push_back(req);
  endtask

  // monitor: compares when the design has produced the queued result
  always @(negedge clk) begin
    while (q_tgt.size() > 0 && q_tgt[0] <= cyc) begin
      check({q_req[0], " word"}, rd_data, q_rd[0]);
      check({q_req[0], " irq"}, {61'd0, irq}, {61'd0, q_irq[0]});
      void'(q_tgt.pop_front());
      void'(q_rd.pop_front());
      void'(q_irq.pop_front());
      void'(q_req.pop_front());
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; evt = '0; mode = '0;
    {m0, m1, s0, ku, m2, c0, c1, c2, kp, kk, s1, s2} = 64'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset word", rd_data, 64'd0);
    check("R1 reset irq", {61'd0, irq}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 after release", rd_data, 64'd0);

    // R3: control 00 does not count even with all events high
    for (int i = 0; i < 3; i++) drive(0, 0, 16'hFFFF, 3'd0, "R1 R3 off");

    // R2: field layout round trip, controls off so values hold
    drive(1, mkw(16'h1234, 16'hABCD, 14'h2A5A, 1, 0, 1, 0, 0, 0, 0, 4'h6, 4'h9), 0, 0, "R2 load");
    drive(0, 0, 16'hFFFF, 3'd1, "R2 R3 hold");
    drive(1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R2 all ones");
    drive(1, 64'h0, 0, 0, "R2 clear");

    // R3 R4: select routing across patterns and modes
    drive(1, mkw(0, 0, 0, 1, 0, 0, 0, 2'b01, 2'b01, 2'b01, 4'd5, 4'd9), 0, 0, "R4 setup");
    begin
      logic [15:0] pats [6] = '{16'h0002, 16'h0001, 16'h0020, 16'h0200, 16'hFFFF, 16'h0000};
      for (int p = 0; p < 6; p++)
        for (int md = 0; md < 5; md++) drive(0, 0, pats[p], 3'(md), "R3 R4 select");
    end
    drive(1, mkw(7, 7, 7, 0, 0, 0, 0, 2'b01, 2'b01, 2'b01, 4'd15, 4'd0), 0, 0, "R4 reselect");
    drive(0, 0, 16'h8001, 3'd2, "R4 edges");
    drive(0, 0, 16'h7FFE, 3'd2, "R4 others");

    // R5: single kill bits, all mode codes
    for (int k = 0; k < 3; k++) begin
      drive(1, mkw(0, 0, 0, 0, k == 0, k == 1, k == 2, 2'b01, 2'b01, 2'b01, 0, 0), 0, 0, "R5 setup");
      for (int md = 0; md < 8; md++) drive(0, 0, 16'hFFFF, 3'(md), "R5 kill");
    end

    // R6: all kills, executive and supervisor only
    drive(1, mkw(0, 0, 0, 0, 1, 1, 1, 2'b01, 2'b10, 2'b11, 0, 0), 0, 0, "R6 setup");
    for (int r = 0; r < 2; r++)
      for (int md = 0; md < 8; md++) drive(0, 0, 16'h0001, 3'(md), "R6 allkill");

    // R7: 256 period on each counter
    drive(1, mkw(16'h02FE, 16'h00FD, 14'h00FE, 0, 0, 0, 0, 2'b11, 2'b11, 2'b11, 0, 0), 0, 0, "R7 setup");
    for (int i = 0; i < 4; i++) drive(0, 0, 16'h0001, 3'd1, "R7 period256");

    // R8 R10: full-range wrap, and 01 wrapping silently
    drive(1, mkw(16'hFFFE, 16'hFFFE, 14'h3FFE, 0, 0, 0, 0, 2'b10, 2'b01, 2'b10, 0, 0), 0, 0, "R8 setup");
    for (int i = 0; i < 3; i++) drive(0, 0, 16'h0001, 3'd3, "R8 R10 wrap");

    // R9: write beats increment, no pulse
    drive(1, mkw(16'h00FF, 16'h00FF, 14'h00FF, 0, 0, 0, 0, 2'b11, 2'b11, 2'b11, 0, 0), 16'hFFFF, 3'd0, "R9 setup");
    drive(1, mkw(16'h00FF, 16'hFFFF, 14'h3FFF, 0, 0, 0, 0, 2'b11, 2'b10, 2'b10, 0, 0), 16'hFFFF, 3'd0, "R9 write wins");
    drive(0, 0, 16'hFFFF, 3'd0, "R9 then count");

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] w;
      w = {$urandom, $urandom};
      drive(($urandom % 32) == 0, w, 16'($urandom), 3'($urandom % 8), "R3 R5 R7 R8 mixed");
    end

    drive(0, 0, 0, 0, "R3 idle");
    repeat (4) @(posedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule